// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a clocked sequencer for a 64K-location, one-bit-wide asynchronous static RAM whose data input and data output are separate pins. A host hands over one request at a time through a valid/ready port: a 16-bit address, a write flag and a single write bit. The controller then runs one fixed-length memory slot. It drives the active-low chip select, the active-low write strobe, the address and the write data, and it returns a single-cycle completion pulse. For a read, that pulse carries the bit taken from the memory's output pin.

Every timing figure of the memory is a parameter counted in clock cycles. `T_CYCLE` is the slot length and the minimum cycle time. `T_WP` is the width of the write strobe. `T_DW` is the data-valid window before the write strobe rises. `T_ACCESS` is the access delay after the address settles. The parameters must satisfy T_DW ≤ T_WP ≤ T_CYCLE and T_ACCESS < T_CYCLE, and an elaboration-time check enforces this. Reads and writes take the same slot. Each write is closed by the rising write strobe. Between two slots the chip select returns high for at least one cycle (standby). Every memory-side output comes from a flop.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block comes out of reset two clock edges after `rst_n` rises.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset the block is in standby: `mem_ce_n`=1, `mem_we_n`=1, `rsp_done`=0, `rsp_rdata`=0. `req_ready` is 0 while reset is in force and 1 once reset has been released.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle in which `rsp_done` is 1. Each accepted request produces exactly one memory slot.
- R3: On the edge that accepts a request, `mem_ce_n` falls and `mem_addr` takes the request address. `mem_ce_n` then stays low for exactly `T_CYCLE` cycles. During a read slot `mem_we_n` stays 1.
- R4: A read returns the value of `mem_dout` that is present during cycle `T_ACCESS` of the slot, where cycle 0 is the first cycle with `mem_ce_n` low. That value appears on `rsp_rdata` in the cycle in which `rsp_done` is 1.
- R5: In a write slot, `mem_we_n` falls together with `mem_ce_n`, stays low for exactly `T_WP` cycles, and is never low while `mem_ce_n` is high.
- R6: In a write slot, `mem_din` carries the request's write bit from the fall of `mem_ce_n` and stays stable for the whole time `mem_we_n` is low. This covers the `T_DW` window before the rising edge.
- R7: `mem_addr` stays stable for as long as `mem_ce_n` is low.
- R8: `rsp_done` is a one-cycle pulse. It is 1 in the first cycle after `mem_ce_n` returns high at the end of a slot, and it is never 1 while `mem_ce_n` is low.
- R9: Completing a write leaves `rsp_rdata` unchanged.
- R10: Values on `mem_dout` outside cycle `T_ACCESS` of a read slot have no effect. `rsp_rdata` keeps the sampled bit while `mem_dout` changes, both during idle time and later in the slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write bit |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit read by the last read slot |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 16 | Memory address |
| mem_din | output | 1 | Memory data input |
| mem_dout | input | 1 | Memory data output |

## Verification
The assertions rely on the timing parameters meeting their stated ordering. The elaboration check guards that ordering, and the default values satisfy it. The assertions also rely on the host holding its request fields while `req_valid` waits for `req_ready`. The bench's driver task sets all request fields before it raises `req_valid` and leaves them alone until the accepting edge has passed. The bench's memory model drives the true stored bit on `mem_dout` only during the one cycle the controller should sample, and drives its inverse at every other time. A read that samples early or late therefore returns a wrong bit and is caught at the scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Operation held by the controller for the length of one memory slot
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } slot_op_t;

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/sram_slot_timer.sv
module sram_slot_timer #(
  parameter int T_CYCLE = 5,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = busy_q && (cnt_q == CNT_W'(T_CYCLE - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  // R2
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !busy_q);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen #(
  parameter int ADDR_W = 16,
  parameter int T_WP   = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              start_wdata_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              last_i,
  output logic              ce_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              din_o
);

  logic              ce_q, ce_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              din_q, din_d;

  always_comb begin
    ce_d   = ce_q;
    we_d   = we_q;
    addr_d = addr_q;
    din_d  = din_q;
    if (start_i) begin
      ce_d   = 1'b0;
      we_d   = !start_wr_i;
      addr_d = start_addr_i;
      if (start_wr_i) din_d = start_wdata_i;
    end else if (busy_i) begin
      if (!we_q && (cnt_i == CNT_W'(T_WP - 1))) we_d = 1'b1;
      if (last_i) begin
        ce_d = 1'b1;
        we_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= 1'b0;
    end else begin
      ce_q   <= ce_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      din_q  <= din_d;
    end
  end

  assign ce_no  = ce_q;
  assign we_no  = we_q;
  assign addr_o = addr_q;
  assign din_o  = din_q;

  // Checker counter: cycles the write strobe has been low
  logic [CNT_W-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    we_low_cnt <= '0;
    else if (!we_q) we_low_cnt <= we_low_cnt + 1'b1;
    else            we_low_cnt <= '0;
  end

  // R5
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !we_q |-> !ce_q);
  // R5
  wp_width_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(we_q) |-> (we_low_cnt == CNT_W'(T_WP)));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ce_q && $past(!ce_q)) |-> $stable(addr_q));
  // R6
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!we_q && $past(!we_q)) |-> $stable(din_q));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int T_ACCESS = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  input  logic             is_read_i,
  input  logic             mem_dout_i,
  output logic             done_o,
  output logic             rdata_o
);

  logic samp_q, samp_d;
  logic done_q, done_d;
  logic rdata_q, rdata_d;
  logic hit;

  assign hit = busy_i && is_read_i && (cnt_i == CNT_W'(T_ACCESS));

  always_comb begin
    samp_d  = hit ? mem_dout_i : samp_q;
    done_d  = last_i;
    rdata_d = (last_i && is_read_i) ? samp_d : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R9
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!last_i || !is_read_i) |=> $stable(rdata_q));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int T_CYCLE  = 5,
  parameter int T_WP     = 4,
  parameter int T_DW     = 3,
  parameter int T_ACCESS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wdata,
  output logic              rsp_done,
  output logic              rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  input  logic              mem_dout
);

  localparam int CNT_W = $clog2(T_CYCLE + 1);

  initial begin : param_order
    param_order_chk: assert ((T_DW >= 1) && (T_DW <= T_WP) && (T_WP <= T_CYCLE)
                             && (T_ACCESS < T_CYCLE))
      else $error("timing parameters out of order");
  end

  logic             rst_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             start;
  slot_op_t         op_q, op_d;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_q)
  );

  assign req_ready = rst_q && !busy;
  assign start     = req_valid && req_ready;

  always_comb begin
    op_d = op_q;
    if (start)     op_d = req_write ? OP_WRITE : OP_READ;
    else if (last) op_d = OP_IDLE;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) op_q <= OP_IDLE;
    else        op_q <= op_d;
  end

  sram_slot_timer #(.T_CYCLE(T_CYCLE), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_ni(rst_q), .start_i(start),
    .busy_o(busy), .cnt_o(cnt), .last_o(last)
  );

  sram_strobe_gen #(.ADDR_W(ADDR_W), .T_WP(T_WP), .CNT_W(CNT_W)) u_strobe (
    .clk(clk), .rst_ni(rst_q), .start_i(start), .start_wr_i(req_write),
    .start_addr_i(req_addr), .start_wdata_i(req_wdata),
    .busy_i(busy), .cnt_i(cnt), .last_i(last),
    .ce_no(mem_ce_n), .we_no(mem_we_n), .addr_o(mem_addr), .din_o(mem_din)
  );

  sram_read_capture #(.T_ACCESS(T_ACCESS), .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_ni(rst_q), .busy_i(busy), .cnt_i(cnt), .last_i(last),
    .is_read_i(op_q == OP_READ), .mem_dout_i(mem_dout),
    .done_o(rsp_done), .rdata_o(rsp_rdata)
  );

  // Checker counter: cycles chip select has been low
  logic [CNT_W-1:0] ce_low_cnt;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)         ce_low_cnt <= '0;
    else if (!mem_ce_n) ce_low_cnt <= ce_low_cnt + 1'b1;
    else                ce_low_cnt <= '0;
  end

  // R2
  ready_low_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !mem_ce_n |-> !req_ready);
  // R3
  ce_width_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(mem_ce_n) |-> (ce_low_cnt == CNT_W'(T_CYCLE)));
  // R3
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (op_q == OP_READ) |-> mem_we_n);
  // R8
  done_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(mem_ce_n) |-> rsp_done);
  // R8
  done_not_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_done |-> mem_ce_n);

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;

  localparam int T_CYCLE  = 5;
  localparam int T_WP     = 4;
  localparam int T_DW     = 3;
  localparam int T_ACCESS = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        req_write;
  logic        req_wdata;
  logic        rsp_done;
  logic        rsp_rdata;
  logic        mem_ce_n;
  logic        mem_we_n;
  logic [15:0] mem_addr;
  logic        mem_din;
  logic        mem_dout;

  sram_cycle_ctrl #(.ADDR_W(16), .T_CYCLE(T_CYCLE), .T_WP(T_WP), .T_DW(T_DW),
                    .T_ACCESS(T_ACCESS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit wr;
    bit wdata;
    int addr;
    bit exp_rdata;
  } item_t;

  item_t launchq[$];
  item_t sbq[$];
  item_t cur;

  bit mdl_mem[int];
  bit ref_mem[int];
  bit last_rd = 1'b0;

  function automatic bit mget(input int a);
    return mdl_mem.exists(a) ? mdl_mem[a] : 1'b0;
  endfunction
  function automatic bit rget(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
  endfunction

  // Memory model and protocol monitor, all at the falling edge
  bit   mon_en = 1'b0;
  logic prev_ce = 1'b1, prev_we = 1'b1, prev_din = 1'b0, prev_done = 1'b0;
  logic [15:0] prev_addr = '0;
  int   ce_len = 0, we_len = 0, age = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_we_n && !prev_we) mdl_mem[int'(prev_addr)] = prev_din;
      if (!mem_ce_n && prev_ce) begin
        ce_len = 0;
        we_len = 0;
        if (launchq.size() == 0) check(1'b0, "R2", "slot without request", 1, 0);
        else begin
          cur = launchq.pop_front();
          check(int'(mem_addr) == cur.addr, "R3", "address at slot start",
                int'(mem_addr), cur.addr);
          check(mem_we_n == !cur.wr, "R3", "strobe at slot start",
                int'(mem_we_n), int'(!cur.wr));
        end
      end
      if (!mem_ce_n) ce_len++;
      if (!mem_ce_n && !prev_ce)
        check(mem_addr == prev_addr, "R7", "address moved in slot",
              int'(mem_addr), int'(prev_addr));
      if (!mem_we_n) begin
        we_len++;
        if (!prev_we) check(mem_din == prev_din, "R6", "din moved under strobe",
                            int'(mem_din), int'(prev_din));
        if (mem_ce_n) check(1'b0, "R5", "strobe low outside chip select", 0, 1);
      end
      if (mem_we_n && !prev_we) begin
        check(we_len == T_WP, "R5", "strobe width", we_len, T_WP);
        check(prev_din == cur.wdata, "R6", "write bit", int'(prev_din),
              int'(cur.wdata));
        we_len = 0;
      end
      if (mem_ce_n && !prev_ce) begin
        check(ce_len == T_CYCLE, "R3", "chip select width", ce_len, T_CYCLE);
        check(rsp_done == 1'b1, "R8", "done after slot", int'(rsp_done), 1);
      end
      if (rsp_done && !mem_ce_n) check(1'b0, "R8", "done inside slot", 1, 0);
      if (rsp_done && prev_done) check(1'b0, "R8", "done longer than one cycle", 1, 0);
      if (rsp_done) begin
        if (sbq.size() == 0) check(1'b0, "R2", "done without request", 1, 0);
        else begin
          item_t e;
          e = sbq.pop_front();
          if (e.wr) check(rsp_rdata == e.exp_rdata, "R9", "rdata after write",
                          int'(rsp_rdata), int'(e.exp_rdata));
          else      check(rsp_rdata == e.exp_rdata, "R4 R10", "read bit",
                          int'(rsp_rdata), int'(e.exp_rdata));
        end
      end
    end
    // data output: true bit only in the one sampling cycle, inverse otherwise
    if (mem_ce_n === 1'b0 && mem_we_n === 1'b1) age++;
    else age = 0;
    mem_dout = (age == T_ACCESS + 1) ? mget(int'(mem_addr)) : !mget(int'(mem_addr));
    prev_ce   = mem_ce_n;
    prev_we   = mem_we_n;
    prev_din  = mem_din;
    prev_addr = mem_addr;
    prev_done = rsp_done;
  end

  // Driver: called at a falling edge, returns at a falling edge
  task automatic do_op(input int a, input bit wr, input bit d);
    item_t it;
    req_addr  = 16'(a);
    req_write = wr;
    req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.wdata = d; it.addr = a;
    if (wr) begin
      ref_mem[a] = d;
      it.exp_rdata = last_rd;
    end else begin
      it.exp_rdata = rget(a);
      last_rd = it.exp_rdata;
    end
    launchq.push_back(it);
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_write = 1'b0;
    req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R1", "ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_ce_n == 1'b1, "R1", "ce_n after reset", int'(mem_ce_n), 1);
    check(mem_we_n == 1'b1, "R1", "we_n after reset", int'(mem_we_n), 1);
    check(rsp_done == 1'b0, "R1", "done after reset", int'(rsp_done), 0);
    check(rsp_rdata == 1'b0, "R1", "rdata after reset", int'(rsp_rdata), 0);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    mon_en = 1'b1;

    // R5 R6: writes at the address corners, then read back (R4)
    do_op(16'h0000, 1'b1, 1'b1); drain();
    do_op(16'hFFFF, 1'b1, 1'b1); drain();
    do_op(16'h1234, 1'b1, 1'b0); drain();
    do_op(16'h00FF, 1'b1, 1'b1); drain();
    do_op(16'h0000, 1'b0, 1'b0); drain();
    do_op(16'hFFFF, 1'b0, 1'b0); drain();
    do_op(16'h1234, 1'b0, 1'b0); drain();
    do_op(16'h00FF, 1'b0, 1'b0); drain();
    do_op(16'h4321, 1'b0, 1'b0); drain();

    // R10: rdata holds over idle cycles while the model flips mem_dout
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(rsp_rdata == last_rd, "R10", "rdata held while idle",
            int'(rsp_rdata), int'(last_rd));
    end

    // R9: a write after a read that returned 1 keeps rdata at 1
    do_op(16'h0000, 1'b0, 1'b0); drain();
    do_op(16'h0000, 1'b1, 1'b0); drain();
    do_op(16'h0000, 1'b0, 1'b0); drain();

    // Back-to-back walking-one addresses, writes then reads (R2 R3 R8)
    for (int i = 0; i < 16; i++) do_op(1 << i, 1'b1, bit'(i % 2));
    for (int i = 0; i < 16; i++) do_op(1 << i, 1'b0, 1'b0);
    drain();

    // Interleaved read/write at one address
    for (int i = 0; i < 6; i++) do_op(16'hA5A5, bit'(i % 2 == 0), bit'(i / 2 % 2));
    drain();

    check(launchq.size() == 0, "R2", "slots match requests", launchq.size(), 0);
    check(sbq.size() == 0, "R2", "dones match requests", sbq.size(), 0);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule